// File: doc/BRIEF.md
# Alignment-Mode Serial Readout Controller

This block sits in the serial readout path of a rotary magnetic position sensor. Each time the chip-select line falls, it captures one frame word into a shift register. It then shifts that word out, most significant bit first, on rising edges of the serial clock. The frame word has three parts:

- a 10-bit payload;
- an "increase" flag bit;
- a "decrease" flag bit.

In normal operation the payload is the angle. The flags copy two field-strength status inputs.

The controller also has a sticky alignment mode, used to centre the magnet over the die. To enter it, the program pin is held high across a chip-select falling edge, with a minimum setup time before the edge and a minimum hold time after it. Both times are counted in system-clock cycles. After entry, every frame carries the displacement amplitude instead of the angle. Both flags then act as a "well aligned" indicator: they read 1 in the frame word, and the two active-low flag pins are pulled low, whenever the amplitude is below a threshold. Only reset leaves the mode. All pins are sampled by one system clock, and the serial clock is assumed to run well below it.

Top module: `align_ssi_ctrl`

## Requirements
- R1: After reset the block is in normal mode, `sdo_oe` is 0 and `sdo` is 0.
- R2: At a chip-select falling edge the frame word {payload[9:0], inc, dec} (12 bits) is captured. From the next cycle on, `sdo_oe` is 1 and `sdo` shows bit 11.
- R3: Each rising edge of `sclk` while chip-select is low advances the output by one bit, MSB first. A frame keeps the value captured at its falling edge even if the inputs change during the frame.
- R4: From the cycle after chip-select is sampled high, `sdo_oe` and `sdo` are 0.
- R5: Alignment mode is entered when `prog_pin` is high for at least SETUP_CYC cycles before a chip-select falling edge and stays high for at least HOLD_CYC cycles after it. The frame that starts at the entry edge still carries the angle.
- R6: A chip-select falling edge with `prog_pin` low starts an ordinary frame and leaves the mode unchanged.
- R7: No entry occurs if the setup time is too short or `prog_pin` drops before the hold time ends.
- R8: Once entered, alignment mode stays active regardless of pin activity until reset. Reset returns the block to normal mode.
- R9: In alignment mode the payload is `ampl`.
- R10: In alignment mode, when `ampl` < THRESH (32), both flag bits of the word are 1 and `flag_inc_n`/`flag_dec_n` are 0. When `ampl` >= THRESH, the flag bits are 0 and the pins are 1.
- R11: In normal mode the payload is `angle`. The word flag bits equal `mag_inc`/`mag_dec`, and the pins are their inverses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all pins |
| rst_n | input | 1 | Active-low power-on reset |
| sel_n | input | 1 | Active-low chip select; its falling edge starts a frame |
| prog_pin | input | 1 | Mode qualifier pin |
| sclk | input | 1 | Serial clock; rising edges advance the data |
| angle | input | 10 | Angle value |
| ampl | input | 10 | Displacement amplitude |
| mag_inc | input | 1 | Normal-mode field increase status |
| mag_dec | input | 1 | Normal-mode field decrease status |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data output enable (frame active) |
| flag_inc_n | output | 1 | Active-low increase/aligned pin |
| flag_dec_n | output | 1 | Active-low decrease/aligned pin |

## Verification
The bench builds the block with DATA_W=10 and THRESH=32, and shortens SETUP_CYC and HOLD_CYC to 4 cycles. The short windows make it cheap to reach an entry attempt whose setup is one cycle too short and one whose hold is cut to two cycles, next to a valid entry with margin. The 10-bit payload lets the amplitude boundary at 31/32 and the extremes 0 and 1023 be driven directly. Random angle, amplitude and flag inputs change during frames, which exercises the capture at the chip-select edge.

// File: rtl/align_ssi_pkg.sv
package align_ssi_pkg;
  typedef enum logic {
    MODE_ANGLE = 1'b0,
    MODE_ALIGN = 1'b1
  } mode_e;
endpackage

// File: rtl/align_entry_det.sv
module align_entry_det
  import align_ssi_pkg::*;
#(
  parameter int SETUP_CYC = 8,
  parameter int HOLD_CYC  = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_fall,
  input  logic  prog,
  output mode_e mode,
  output logic  enter_evt
);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [SW-1:0] setup_cnt;
  logic [HW-1:0] hold_cnt;
  logic          armed;
  logic          setup_met;

  // setup is met when prog was high in SETUP_CYC samples before this edge
  assign setup_met = int'(setup_cnt) >= SETUP_CYC;
  assign enter_evt = armed && prog && (int'(hold_cnt) + 1 >= HOLD_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_cnt <= '0;
      hold_cnt  <= '0;
      armed     <= 1'b0;
      mode      <= MODE_ANGLE;
    end else begin
      if (!prog) setup_cnt <= '0;
      else if (!setup_met) setup_cnt <= setup_cnt + 1'b1;

      if (enter_evt) begin
        mode  <= MODE_ALIGN;
        armed <= 1'b0;
      end else if (armed) begin
        if (!prog) armed <= 1'b0;
        else hold_cnt <= hold_cnt + 1'b1;
      end else if (sel_fall && prog && setup_met) begin
        armed    <= 1'b1;
        hold_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ssi_word_sel.sv
module ssi_word_sel
  import align_ssi_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int THRESH = 32
) (
  input  mode_e             mode,
  input  logic [DATA_W-1:0] angle,
  input  logic [DATA_W-1:0] ampl,
  input  logic              mag_inc,
  input  logic              mag_dec,
  output logic [DATA_W+1:0] word,
  output logic              flag_inc_n,
  output logic              flag_dec_n
);
  function automatic logic below_thr(input logic [DATA_W-1:0] a);
    return int'(a) < THRESH;
  endfunction

  function automatic logic [DATA_W+1:0] build_word(
      input mode_e m, input logic [DATA_W-1:0] ang, input logic [DATA_W-1:0] amp,
      input logic inc, input logic dec);
    logic ok;
    ok = below_thr(amp);
    if (m == MODE_ALIGN) return {amp, ok, ok};
    return {ang, inc, dec};
  endfunction

  assign word       = build_word(mode, angle, ampl, mag_inc, mag_dec);
  assign flag_inc_n = ~word[1];
  assign flag_dec_n = ~word[0];
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n,
  input  logic               sclk,
  input  logic [FRAME_W-1:0] load_word,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               sel_fall,
  output logic               sclk_rise
);
  logic               sel_q;
  logic               sclk_q;
  logic [FRAME_W-1:0] shreg;

  assign sel_fall  = sel_q & ~sel_n;
  assign sclk_rise = sclk & ~sclk_q & ~sel_q & ~sel_n;
  assign sdo_oe    = ~sel_q;
  assign sdo       = ~sel_q & shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b0;
      shreg  <= '0;
    end else begin
      sel_q  <= sel_n;
      sclk_q <= sclk;
      if (sel_fall) shreg <= load_word;
      else if (sclk_rise) shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/align_ssi_ctrl.sv
module align_ssi_ctrl
  import align_ssi_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int THRESH    = 32,
  parameter int SETUP_CYC = 8,
  parameter int HOLD_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              prog_pin,
  input  logic              sclk,
  input  logic [DATA_W-1:0] angle,
  input  logic [DATA_W-1:0] ampl,
  input  logic              mag_inc,
  input  logic              mag_dec,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              flag_inc_n,
  output logic              flag_dec_n
);
  localparam int FRAME_W = DATA_W + 2;

  mode_e              mode;
  logic               align_q;
  logic               enter_evt;
  logic               sel_fall;
  logic               sclk_rise;
  logic [FRAME_W-1:0] word;

  assign align_q = (mode == MODE_ALIGN);

  align_entry_det #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_det (
    .clk(clk), .rst_n(rst_n), .sel_fall(sel_fall), .prog(prog_pin),
    .mode(mode), .enter_evt(enter_evt)
  );

  ssi_word_sel #(.DATA_W(DATA_W), .THRESH(THRESH)) u_sel (
    .mode(mode), .angle(angle), .ampl(ampl), .mag_inc(mag_inc), .mag_dec(mag_dec),
    .word(word), .flag_inc_n(flag_inc_n), .flag_dec_n(flag_dec_n)
  );

  ssi_shifter #(.FRAME_W(FRAME_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .load_word(word),
    .sdo(sdo), .sdo_oe(sdo_oe), .sel_fall(sel_fall), .sclk_rise(sclk_rise)
  );
endmodule

// File: rtl/align_ssi_ctrl_chk.sv
module align_ssi_ctrl_chk #(
  parameter int DATA_W = 10,
  parameter int THRESH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              prog_pin,
  input logic [DATA_W-1:0] ampl,
  input logic              mag_inc,
  input logic              mag_dec,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              flag_inc_n,
  input logic              flag_dec_n,
  input logic              align_q,
  input logic              enter_evt,
  input logic              sel_fall
);
  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!align_q && !sdo_oe && !sdo));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (!sdo_oe && !sdo));

  // R5
  entry_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> align_q);

  // R6
  plain_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fall && !prog_pin) |=> $stable(align_q));

  // R8
  sticky_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_q |=> align_q);

  // R10
  aligned_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_q |-> ((int'(ampl) < THRESH) == (!flag_inc_n && !flag_dec_n)));

  // R11
  pass_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !align_q |-> (flag_inc_n == !mag_inc && flag_dec_n == !mag_dec));
endmodule

bind align_ssi_ctrl align_ssi_ctrl_chk #(.DATA_W(DATA_W), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .prog_pin(prog_pin), .ampl(ampl),
  .mag_inc(mag_inc), .mag_dec(mag_dec), .sdo(sdo), .sdo_oe(sdo_oe),
  .flag_inc_n(flag_inc_n), .flag_dec_n(flag_dec_n), .align_q(align_q),
  .enter_evt(enter_evt), .sel_fall(sel_fall)
);

// File: tb/align_ssi_ctrl_test.sv
module align_ssi_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int TH = 32;
  localparam int SU = 4;
  localparam int HO = 4;

  logic clk = 0, rst_n = 0, sel_n = 1, prog_pin = 0, sclk = 0;
  logic [DW-1:0] angle = 0, ampl = 0;
  logic mag_inc = 0, mag_dec = 0;
  logic sdo, sdo_oe, flag_inc_n, flag_dec_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  align_ssi_ctrl #(.DATA_W(DW), .THRESH(TH), .SETUP_CYC(SU), .HOLD_CYC(HO)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .prog_pin(prog_pin), .sclk(sclk),
    .angle(angle), .ampl(ampl), .mag_inc(mag_inc), .mag_dec(mag_dec),
    .sdo(sdo), .sdo_oe(sdo_oe), .flag_inc_n(flag_inc_n), .flag_dec_n(flag_dec_n)
  );

  function automatic logic [DW+1:0] exp_word(bit al, logic [DW-1:0] ang, logic [DW-1:0] amp,
                                             logic i, logic d);
    bit ok;
    ok = (amp < TH);
    if (al) return {amp, ok, ok};
    return {ang, i, d};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reads one frame; optionally changes inputs mid-frame (R3).
  task automatic read_frame(output logic [DW+1:0] w, input bit perturb, input string req);
    sel_n = 0;
    tick(1);
    chk(sdo_oe === 1'b1, {req, " R2 oe"}, sdo_oe, 1);
    for (int b = DW + 1; b >= 0; b--) begin
      w[b] = sdo;
      if (perturb && b == DW - 2) begin
        angle = DW'($urandom); ampl = DW'($urandom);
        mag_inc = 1'($urandom); mag_dec = 1'($urandom);
      end
      sclk = 1; tick(1);
      sclk = 0; tick(1);
    end
    sel_n = 1;
    tick(1);
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R4 idle", {sdo_oe, sdo}, 0);
  endtask

  task automatic frame_check(input bit al, input bit perturb, input string req);
    logic [DW+1:0] w, e;
    e = exp_word(al, angle, ampl, mag_inc, mag_dec);
    read_frame(w, perturb, req);
    chk(w === e, req, w, e);
  endtask

  task automatic pin_check(input bit al, input string req);
    logic [DW+1:0] e;
    tick(1);
    e = exp_word(al, angle, ampl, mag_inc, mag_dec);
    chk(flag_inc_n === ~e[1] && flag_dec_n === ~e[0], req,
        {flag_inc_n, flag_dec_n}, {~e[1], ~e[0]});
  endtask

  // prog high s cycles before the edge, held h cycles after it
  task automatic attempt(input int s, input int h);
    prog_pin = 1;
    tick(s);
    sel_n = 0;
    tick(h);
    prog_pin = 0;
    tick(2);
    sel_n = 1;
    tick(3);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(3);
    rst_n = 1;
    tick(1);
    // R1
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R1 reset outputs", {sdo_oe, sdo}, 0);
    angle = 10'd1023; ampl = 10'd5; mag_inc = 1; mag_dec = 0;
    frame_check(0, 0, "R1 R11 reset mode angle");
    // R11
    pin_check(0, "R11 pass pins");
    // R2 R3: random frames, normal mode, with mid-frame changes
    for (int k = 0; k < 12; k++) begin
      angle = DW'($urandom); ampl = DW'($urandom);
      mag_inc = 1'($urandom); mag_dec = 1'($urandom);
      pin_check(0, "R11 random pins");
      frame_check(0, k[0], "R3 R11 normal frame");
    end
    // R6: prog low at each edge
    angle = 10'h2AA; ampl = 10'd3;
    frame_check(0, 0, "R6 plain frame");
    // R7: setup one cycle short
    attempt(SU - 1, HO + 4);
    angle = 10'h155; ampl = 10'd7;
    frame_check(0, 0, "R7 short setup no entry");
    // R7: hold cut short
    attempt(SU + 2, 2);
    frame_check(0, 0, "R7 short hold no entry");
    // R5: valid entry; entry frame still carries the angle
    angle = 10'h0F0; ampl = 10'd9;
    prog_pin = 1; tick(SU + 2);
    begin
      logic [DW+1:0] w, e;
      e = exp_word(0, angle, ampl, mag_inc, mag_dec);
      read_frame(w, 0, "R5 entry frame");
      chk(w === e, "R5 entry frame angle", w, e);
    end
    prog_pin = 0; tick(2);
    frame_check(1, 0, "R5 R9 after entry");
    // R10 boundaries
    ampl = 10'd31; pin_check(1, "R10 pins 31"); frame_check(1, 0, "R10 word 31");
    ampl = 10'd32; pin_check(1, "R10 pins 32"); frame_check(1, 0, "R10 word 32");
    ampl = 10'd0;  pin_check(1, "R10 pins 0");  frame_check(1, 0, "R10 word 0");
    ampl = 10'd1023; pin_check(1, "R10 pins 1023"); frame_check(1, 1, "R9 R10 word 1023");
    // R8 R9: random, with pin activity including prog toggles
    for (int k = 0; k < 10; k++) begin
      angle = DW'($urandom); ampl = DW'($urandom % 64);
      mag_inc = 1'($urandom); mag_dec = 1'($urandom);
      prog_pin = 1'($urandom);
      pin_check(1, "R10 random pins");
      frame_check(1, k[0], "R8 R9 align frame");
      prog_pin = 0;
    end
    // R8: reset returns to normal mode
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    angle = 10'h3C3; ampl = 10'd1;
    frame_check(0, 0, "R8 reset leaves align");
    pin_check(0, "R8 R11 pins after reset");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule